// File: doc/BRIEF.md
# Pointer-Register Byte CPU Datapath

This block is the datapath and sequencer of a small 8-bit processor. It holds sixteen 16-bit pointer registers and one 8-bit accumulator. Every memory access goes through one of the pointer registers. That register is chosen by one of three 4-bit selectors: the low nibble of the current opcode, the program-pointer selector (parameter `PC_SEL`, default 0) or the data-pointer selector (parameter `DP_SEL`, default 1). The block executes opcode groups 0x0 to 0x6: load, increment, decrement, two-byte short branch, load with post-increment, store, and device input/output. All other opcodes complete as no-operations.

Memory is read combinationally: the byte on `mem_rdata` belongs to the address driven in the same cycle. A write is a one-cycle `mem_we` pulse. The device port sends bytes out on `dev_out` with a `dev_we` pulse, and it samples `dev_in` for input. A wait opcode parks the block in a waiting state until `wake_req` is asserted.

A small state machine sequences the work. Its states are ST_FETCH, ST_EXEC, ST_BRANCH, ST_POSTINC and ST_IDLE. The transitions are:
- reset → ST_FETCH
- ST_FETCH → ST_EXEC (always)
- ST_EXEC → ST_BRANCH (group 0x3)
- ST_EXEC → ST_POSTINC (group 0x4)
- ST_EXEC → ST_IDLE (opcode 0x00)
- ST_EXEC → ST_FETCH (every other opcode)
- ST_BRANCH → ST_FETCH
- ST_POSTINC → ST_FETCH
- ST_IDLE → ST_IDLE while `wake_req` is low
- ST_IDLE → ST_FETCH when `wake_req` is high

Top module: `ptrcpu_core`

## Requirements
- R1: While `rst_n` is low, all pointer registers and the accumulator are cleared and the block is in ST_FETCH. During reset, `mem_we`, `dev_we`, `done` and `idle` are 0 and `mem_addr` is 0. In the first cycle after reset is released, the block fetches from address 0.
- R2: In ST_FETCH, `mem_addr` equals R(PC_SEL) and the byte read becomes the opcode. At that clock edge R(PC_SEL) is incremented and the next state is ST_EXEC.
- R3: Opcode 0x0n with n≠0 drives `mem_addr` with R(n) in ST_EXEC and loads the accumulator from `mem_rdata`.
- R4: Opcode 0x00 moves to ST_IDLE. In ST_IDLE, `idle` is 1 and no write strobe is issued. The block leaves ST_IDLE on the first edge at which `wake_req` is 1. In any other state, `wake_req` has no effect.
- R5: Opcode 0x1n increments R(n) and opcode 0x2n decrements R(n), both modulo 2^16 (0xFFFF+1 gives 0x0000, 0x0000−1 gives 0xFFFF).
- R6: Opcode 0x3n reads the operand byte at R(PC_SEL) in ST_EXEC. The branch is taken when n=0, or when n=2 and the accumulator is 0x00; any other n never branches. On a taken branch, ST_BRANCH replaces bits 7:0 of R(PC_SEL) with the operand and keeps bits 15:8. On a branch not taken, ST_BRANCH increments R(PC_SEL).
- R7: Opcode 0x4n loads the accumulator from address R(n) in ST_EXEC, then increments R(n) in ST_POSTINC.
- R8: Opcode 0x5n drives `mem_addr` with R(n), `mem_wdata` with the accumulator and `mem_we` high, for the one ST_EXEC cycle.
- R9: Opcodes 0x61 to 0x67 read address R(DP_SEL) and present that byte on `dev_out` with `dev_we` high for one cycle, and increment R(DP_SEL).
- R10: Opcode 0x60 increments R(DP_SEL) only, with `dev_we` and `mem_we` low.
- R11: Opcodes 0x68 to 0x6F load the accumulator from `dev_in`.
- R12: Opcodes 0x70 to 0xFF finish in ST_EXEC with no register, accumulator or strobe activity.
- R13: `done` is high for exactly the last cycle of each instruction, and the following state is ST_FETCH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory address, always the currently selected pointer register |
| mem_rdata | input | 8 | Memory read byte for the current address |
| mem_wdata | output | 8 | Memory write byte (the accumulator) |
| mem_we | output | 1 | Memory write strobe |
| dev_in | input | 8 | Device input byte |
| dev_out | output | 8 | Device output byte |
| dev_we | output | 1 | Device output strobe |
| wake_req | input | 1 | Releases the block from the waiting state |
| done | output | 1 | Last cycle of an instruction |
| idle | output | 1 | Block is in the waiting state |

## Verification
The hardest case to reach from the ports is the short branch in both directions. It depends on accumulator contents that can only be set through memory or device loads. It also needs a data pointer that sits near the 0xFFFF wrap, which only repeated decrements can produce. The stimulus program first takes an input byte, then walks a pointer below zero by decrementing it, and stores and reloads through that pointer. This makes the conditional branch see both a zero and a non-zero accumulator. Two runs with different device and data bytes send the program down different branch and wait paths. A cycle-accurate model in the bench predicts every address, strobe and status bit.

// File: rtl/ptrcpu_pkg.sv
package ptrcpu_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_EXEC,
        ST_BRANCH,
        ST_POSTINC,
        ST_IDLE
    } cpu_state_e;

    typedef enum logic [1:0] {
        SEL_N,
        SEL_P,
        SEL_X
    } reg_sel_e;

    typedef enum logic [1:0] {
        RF_HOLD,
        RF_INC,
        RF_DEC,
        RF_SETLO
    } rf_op_e;

    typedef enum logic [1:0] {
        DSRC_NONE,
        DSRC_MEM,
        DSRC_DEV
    } d_src_e;

    localparam logic [3:0] GRP_LOAD   = 4'h0;
    localparam logic [3:0] GRP_INC    = 4'h1;
    localparam logic [3:0] GRP_DEC    = 4'h2;
    localparam logic [3:0] GRP_BRANCH = 4'h3;
    localparam logic [3:0] GRP_LDINC  = 4'h4;
    localparam logic [3:0] GRP_STORE  = 4'h5;
    localparam logic [3:0] GRP_IO     = 4'h6;

endpackage

// File: rtl/ptrcpu_regfile.sv
module ptrcpu_regfile
    import ptrcpu_pkg::*;
#(
    parameter int NREG  = 16,
    parameter int AW    = 16,
    parameter int DW    = 8,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  rf_op_e           op,
    input  logic [DW-1:0]    lo_byte,
    output logic [AW-1:0]    rdata
);

    logic [AW-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [AW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (sel == SEL_W'(i)) begin
                unique case (op)
                    RF_HOLD:  q <= q;
                    RF_INC:   q <= q + AW'(1);
                    RF_DEC:   q <= q - AW'(1);
                    RF_SETLO: q <= {q[AW-1:DW], lo_byte};
                    default:  q <= q;
                endcase
            end
        end
        assign regs[i] = q;
    end

    assign rdata = regs[sel];

    AST_INC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RF_INC) |=> (regs[$past(sel)] == AW'($past(rdata) + AW'(1)))); // R5
    AST_DEC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RF_DEC) |=> (regs[$past(sel)] == AW'($past(rdata) - AW'(1)))); // R5
    AST_SETLO_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RF_SETLO) |=> (regs[$past(sel)][AW-1:DW] == $past(rdata[AW-1:DW]))); // R6

endmodule

// File: rtl/ptrcpu_brcond.sv
module ptrcpu_brcond #(
    parameter int DW = 8
) (
    input  logic [3:0]    cond_code,
    input  logic [DW-1:0] acc,
    output logic          take
);

    always_comb begin
        case (cond_code)
            4'h0:    take = 1'b1;
            4'h2:    take = (acc == '0);
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/ptrcpu_ctrl.sv
module ptrcpu_ctrl
    import ptrcpu_pkg::*;
#(
    parameter int DW    = 8,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             wake_req,
    input  logic             take,
    output logic [SEL_W-1:0] ir_n,
    output reg_sel_e         sel,
    output rf_op_e           rf_op,
    output d_src_e           d_src,
    output logic             b_ld,
    output logic             mem_we,
    output logic             dev_we,
    output logic             done,
    output logic             idle
);

    cpu_state_e state, nxt;
    logic [DW-1:0]    ir_q;
    logic             ir_ld;
    logic [DW-SEL_W-1:0] grp;

    assign ir_n = ir_q[SEL_W-1:0];
    assign grp  = ir_q[DW-1:SEL_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            ir_q  <= '0;
        end else begin
            state <= nxt;
            if (ir_ld) ir_q <= mem_rdata;
        end
    end

    always_comb begin
        nxt    = state;
        sel    = SEL_P;
        rf_op  = RF_HOLD;
        d_src  = DSRC_NONE;
        b_ld   = 1'b0;
        ir_ld  = 1'b0;
        mem_we = 1'b0;
        dev_we = 1'b0;
        done   = 1'b0;
        idle   = 1'b0;
        unique case (state)
            ST_FETCH: begin
                sel   = SEL_P;
                rf_op = RF_INC;
                ir_ld = 1'b1;
                nxt   = ST_EXEC;
            end
            ST_EXEC: begin
                nxt  = ST_FETCH;
                done = 1'b1;
                case (grp)
                    GRP_LOAD: begin
                        if (ir_n == '0) begin
                            done = 1'b0;
                            nxt  = ST_IDLE;
                        end else begin
                            sel   = SEL_N;
                            d_src = DSRC_MEM;
                        end
                    end
                    GRP_INC: begin
                        sel   = SEL_N;
                        rf_op = RF_INC;
                    end
                    GRP_DEC: begin
                        sel   = SEL_N;
                        rf_op = RF_DEC;
                    end
                    GRP_BRANCH: begin
                        sel  = SEL_P;
                        b_ld = 1'b1;
                        done = 1'b0;
                        nxt  = ST_BRANCH;
                    end
                    GRP_LDINC: begin
                        sel   = SEL_N;
                        d_src = DSRC_MEM;
                        done  = 1'b0;
                        nxt   = ST_POSTINC;
                    end
                    GRP_STORE: begin
                        sel    = SEL_N;
                        mem_we = 1'b1;
                    end
                    GRP_IO: begin
                        if (ir_n[SEL_W-1]) begin
                            d_src = DSRC_DEV;
                        end else begin
                            sel    = SEL_X;
                            rf_op  = RF_INC;
                            dev_we = (ir_n != '0);
                        end
                    end
                    default: ;
                endcase
            end
            ST_BRANCH: begin
                sel   = SEL_P;
                rf_op = take ? RF_SETLO : RF_INC;
                done  = 1'b1;
                nxt   = ST_FETCH;
            end
            ST_POSTINC: begin
                sel   = SEL_N;
                rf_op = RF_INC;
                done  = 1'b1;
                nxt   = ST_FETCH;
            end
            ST_IDLE: begin
                idle = 1'b1;
                if (wake_req) nxt = ST_FETCH;
            end
            default: nxt = ST_FETCH;
        endcase
    end

    AST_FETCH_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (state == ST_EXEC)); // R2
    AST_DONE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == ST_FETCH)); // R13
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !wake_req) |=> (state == ST_IDLE)); // R4
    AST_IDLE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wake_req) |=> (state == ST_FETCH)); // R4

endmodule

// File: rtl/ptrcpu_core.sv
module ptrcpu_core
    import ptrcpu_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 16,
    parameter int NREG   = 16,
    parameter int PC_SEL = 0,
    parameter int DP_SEL = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] dev_in,
    output logic [DW-1:0] dev_out,
    output logic          dev_we,
    input  logic          wake_req,
    output logic          done,
    output logic          idle
);

    localparam int SEL_W = $clog2(NREG);

    logic [SEL_W-1:0] ir_n;
    logic [SEL_W-1:0] sel_idx;
    reg_sel_e         sel;
    rf_op_e           rf_op;
    d_src_e           d_src;
    logic             b_ld;
    logic             take;
    logic [DW-1:0]    d_q;
    logic [DW-1:0]    b_q;
    logic [AW-1:0]    rf_rdata;

    ptrcpu_ctrl #(.DW(DW), .SEL_W(SEL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_rdata(mem_rdata),
        .wake_req (wake_req),
        .take     (take),
        .ir_n     (ir_n),
        .sel      (sel),
        .rf_op    (rf_op),
        .d_src    (d_src),
        .b_ld     (b_ld),
        .mem_we   (mem_we),
        .dev_we   (dev_we),
        .done     (done),
        .idle     (idle)
    );

    always_comb begin
        unique case (sel)
            SEL_N:   sel_idx = ir_n;
            SEL_P:   sel_idx = SEL_W'(PC_SEL);
            SEL_X:   sel_idx = SEL_W'(DP_SEL);
            default: sel_idx = ir_n;
        endcase
    end

    ptrcpu_regfile #(.NREG(NREG), .AW(AW), .DW(DW)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel_idx),
        .op     (rf_op),
        .lo_byte(b_q),
        .rdata  (rf_rdata)
    );

    ptrcpu_brcond #(.DW(DW)) u_cond (
        .cond_code(ir_n),
        .acc      (d_q),
        .take     (take)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= '0;
            b_q <= '0;
        end else begin
            unique case (d_src)
                DSRC_MEM: d_q <= mem_rdata;
                DSRC_DEV: d_q <= dev_in;
                default:  d_q <= d_q;
            endcase
            if (b_ld) b_q <= mem_rdata;
        end
    end

    assign mem_addr  = rf_rdata;
    assign mem_wdata = d_q;
    assign dev_out   = mem_rdata;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && dev_we)); // R8
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!mem_we && !dev_we && !done)); // R4
    AST_STORE_NOT_BACKTOBACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R8
    AST_OUT_NOT_BACKTOBACK: assert property (@(posedge clk) disable iff (!rst_n)
        dev_we |=> !dev_we); // R9

endmodule

// File: tb/tb_ptrcpu_core.sv
module tb_ptrcpu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  dev_in = 8'h00;
    logic [7:0]  dev_out;
    logic        dev_we;
    logic        wake_req = 1'b0;
    logic        done;
    logic        idle;

    localparam int PSEL = 0;
    localparam int XSEL = 1;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ptrcpu_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .dev_in(dev_in), .dev_out(dev_out),
        .dev_we(dev_we), .wake_req(wake_req), .done(done), .idle(idle)
    );

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    // reference model state
    logic [15:0] rr [16];
    logic [7:0]  rd, rb, rir;
    int          ph; // 0 fetch, 1 exec, 2 branch, 3 postinc, 4 idle

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic string exec_tag(input logic [7:0] op);
        case (op[7:4])
            4'h0:      return (op[3:0] == 0) ? "R4" : "R3";
            4'h1, 4'h2: return "R5";
            4'h3:      return "R6";
            4'h4:      return "R7";
            4'h5:      return "R8";
            4'h6:      return (op[3:0] == 0) ? "R10" : (op[3] ? "R11" : "R9");
            default:   return "R12";
        endcase
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) rr[i] = '0;
            rd = '0; rb = '0; rir = '0; ph = 0;
            chk("R1", "mem_we in reset", int'(mem_we), 0);
            chk("R1", "dev_we in reset", int'(dev_we), 0);
            chk("R1", "done in reset", int'(done), 0);
            chk("R1", "idle in reset", int'(idle), 0);
            chk("R1", "mem_addr in reset", int'(mem_addr), 0);
        end else begin
            automatic logic [3:0] n = rir[3:0];
            automatic logic [3:0] hi = rir[7:4];
            automatic string tg = "R2";
            automatic int  e_addr = -1;
            automatic int  e_we = 0, e_dwe = 0, e_done = 0, e_idle = 0;
            automatic int  nph = 0;
            automatic bit  take;
            case (ph)
                0: begin
                    tg = "R2"; e_addr = rr[PSEL];
                    rir = ref_mem[rr[PSEL][7:0]];
                    rr[PSEL] = rr[PSEL] + 16'd1;
                    nph = 1;
                end
                1: begin
                    tg = exec_tag(rir); e_done = 1; nph = 0;
                    case (hi)
                        4'h0: if (n == 0) begin e_done = 0; nph = 4; end
                              else begin e_addr = rr[n]; rd = ref_mem[rr[n][7:0]]; end
                        4'h1: rr[n] = rr[n] + 16'd1;
                        4'h2: rr[n] = rr[n] - 16'd1;
                        4'h3: begin e_addr = rr[PSEL]; rb = ref_mem[rr[PSEL][7:0]]; e_done = 0; nph = 2; end
                        4'h4: begin e_addr = rr[n]; rd = ref_mem[rr[n][7:0]]; e_done = 0; nph = 3; end
                        4'h5: begin e_addr = rr[n]; e_we = 1;
                                    chk("R8", "mem_wdata", int'(mem_wdata), int'(rd));
                                    ref_mem[rr[n][7:0]] = rd; end
                        4'h6: if (n[3]) rd = dev_in;
                              else begin
                                  if (n != 0) begin
                                      e_addr = rr[XSEL]; e_dwe = 1;
                                      chk("R9", "dev_out", int'(dev_out), int'(ref_mem[rr[XSEL][7:0]]));
                                  end
                                  rr[XSEL] = rr[XSEL] + 16'd1;
                              end
                        default: ;
                    endcase
                end
                2: begin
                    tg = "R6"; e_done = 1; nph = 0;
                    take = (n == 0) || (n == 2 && rd == 8'h00);
                    if (take) rr[PSEL] = {rr[PSEL][15:8], rb};
                    else      rr[PSEL] = rr[PSEL] + 16'd1;
                end
                3: begin
                    tg = "R7"; e_done = 1; nph = 0;
                    rr[n] = rr[n] + 16'd1;
                end
                default: begin
                    tg = "R4"; e_idle = 1;
                    nph = wake_req ? 0 : 4;
                end
            endcase
            if (e_addr >= 0) chk(tg, "mem_addr", int'(mem_addr), e_addr);
            chk(tg, "mem_we", int'(mem_we), e_we);
            chk(tg, "dev_we", int'(dev_we), e_dwe);
            chk("R13", "done", int'(done), e_done);
            chk(tg, "idle", int'(idle), e_idle);
            ph = nph;
        end
    end

    // wake driver: releases the wait after 6 idle cycles, also pulses wake at other times (R4)
    initial begin
        automatic int idle_cnt = 0;
        automatic int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            if (idle) idle_cnt++; else idle_cnt = 0;
            wake_req = (idle_cnt == 6) || (cyc % 13 == 0 && !idle);
        end
    end

    task automatic load_program(input logic [7:0] fe_val);
        logic [7:0] p [32] = '{
            8'h68, 8'h23, 8'h53, 8'h24, 8'h24, 8'h44, 8'h32, 8'h0A,
            8'h00, 8'h00, 8'h04, 8'h32, 8'h77, 8'h35, 8'h00, 8'h30,
            8'h12, 8'h00, 8'h13, 8'h61, 8'h60, 8'h67, 8'h9C, 8'hF0,
            8'h6F, 8'h21, 8'h51, 8'h41, 8'h00, 8'h01, 8'h30, 8'h1E};
        for (int i = 0; i < 256; i++) begin
            mem[i] = (i < 32) ? p[i] : 8'h00;
        end
        mem[8'hFE] = fe_val;
        for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    endtask

    task automatic run_pass(input logic [7:0] fe_val, input logic [7:0] din1, input logic [7:0] din2);
        @(posedge clk); #1;
        rst_n = 1'b0;
        load_program(fe_val);
        dev_in = din1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (40) @(posedge clk);
        #1 dev_in = din2;
        repeat (140) @(posedge clk);
        #1;
        for (int i = 0; i < 256; i++)
            chk("R8", "memory image", int'(mem[i]), int'(ref_mem[i]));
    endtask

    initial begin
        // pass 1: zero operand at 0xFFFE makes the conditional branch taken (R6)
        run_pass(8'h00, 8'h5A, 8'hC3);
        // pass 2: non-zero operand takes the not-taken path into two waits (R4, R6)
        run_pass(8'h33, 8'h3C, 8'h00);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R13: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule